// File: doc/BRIEF.md
# Two-Step Preamble Gain Controller

This block sets the gain code of a variable-gain amplifier while a packet preamble is arriving, so that the converter input ends near a fixed peak-to-average level. A start pulse from the frame detector begins the sequence. The block takes one windowed power word from an external estimator and converts it to whole decibels by leading-one detection and a small mantissa table. It then forms the next gain as the previous gain plus the measured level minus a 9 dB target, and clamps the result to the 7-bit code range.

The block makes exactly two such updates in each packet. Between them it waits a settle interval of 16 cycles, so the amplifier can respond to the first change. After the second update it locks and holds the code until a packet-end pulse returns it to idle. The code is kept across packets, so the next packet starts from the last gain. Only a reset brings the code back to its initial value.

The states are IDLE, MEAS1, UPD1, SETTLE, MEAS2, UPD2 and LOCKED. The transitions are:
- IDLE to MEAS1 on start.
- MEAS1 to UPD1 on a power word.
- UPD1 to SETTLE, unconditionally.
- SETTLE to MEAS2 when the settle count ends.
- MEAS2 to UPD2 on a power word.
- UPD2 to LOCKED, unconditionally.
- Any state to IDLE on pkt_end.

Top module: `preamble_agc`

## Requirements
- R1: After reset, gain equals GAIN_INIT (48), and busy, locked and gain_stb are 0.
- R2: A start pulse in IDLE makes busy 1 from the next cycle on, until the block locks or is aborted.
- R3: The dB value of a power word is floor((12*k + T[m] + 2)/4). Here k is the bit index of the leading one, m is the two bits just below it (zero-filled below bit 0), and T = {0,4,7,10} for m = 0..3. A zero word gives 0.
- R4: Each update sets gain to the previous gain plus the dB value minus 9, clamped to 0..127.
- R5: Exactly two updates happen per packet. gain_stb is high for one cycle with each new code, and locked is 1 after the second update.
- R6: After the first update the block ignores power words for 16 cycles. If pwr_valid is held high, the second gain_stb comes 18 cycles after the first.
- R7: A start pulse while busy or locked has no effect on gain, busy or locked.
- R8: pkt_end returns the block to IDLE from any state on the next cycle, keeps the current gain, and wins over a start pulse in the same cycle.
- R9: Power words that arrive while the block is in IDLE or LOCKED are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse from the frame detector |
| pkt_end | input | 1 | Packet-end pulse; aborts or unlocks |
| pwr_valid | input | 1 | Power word valid |
| pwr | input | 24 | Windowed power measurement |
| gain | output | 7 | Amplifier gain code, 1 dB per step |
| gain_stb | output | 1 | One-cycle pulse with each new gain code |
| busy | output | 1 | Sequence in progress |
| locked | output | 1 | Both updates done; gain is frozen |

## Verification
Two things can happen in the same cycle: a packet-end pulse and a start pulse. Also, a power word can arrive while the settle count is still running. The bench raises start and pkt_end together while the block is locked, and judges the result by busy and locked being 0 in the next cycle. The bench also holds pwr_valid high with a saturating word through the whole settle window, and sends a start pulse in that window. Only the exact 18-cycle spacing and the expected gain show that the settle words were dropped.

// File: rtl/preamble_agc_pkg.sv
package preamble_agc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MEAS1  = 3'd1,
        ST_UPD1   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_MEAS2  = 3'd4,
        ST_UPD2   = 3'd5,
        ST_LOCKED = 3'd6
    } agc_state_e;
endpackage

// File: rtl/agc_db_lut.sv
// Converts a power word to integer dB via leading-one index and 2-bit mantissa.
module agc_db_lut #(
    parameter int PW  = 24,
    parameter int DBW = 8
) (
    input  logic [PW-1:0]  pwr,
    output logic [DBW-1:0] db
);
    localparam int KW = $clog2(PW);

    logic [KW-1:0]  lead;
    logic           nonzero;
    logic [PW-1:0]  norm;
    logic [1:0]     mant;
    logic [4:0]     frac_q;
    logic [DBW+1:0] sum_q;

    always_comb begin
        lead    = '0;
        nonzero = 1'b0;
        for (int i = 0; i < PW; i++) begin
            if (pwr[i]) begin
                lead    = KW'(i);
                nonzero = 1'b1;
            end
        end
    end

    assign norm = pwr << (KW'(PW - 1) - lead);
    assign mant = norm[PW-2 -: 2];

    always_comb begin
        unique case (mant)
            2'd0: frac_q = 5'd0;
            2'd1: frac_q = 5'd4;
            2'd2: frac_q = 5'd7;
            default: frac_q = 5'd10;
        endcase
    end

    assign sum_q = (DBW+2)'(lead) * (DBW+2)'(12) + (DBW+2)'(frac_q) + (DBW+2)'(2);
    assign db    = nonzero ? sum_q[DBW+1:2] : '0;
endmodule

// File: rtl/agc_gain_calc.sv
// Next gain = previous + measured dB - target, clamped to the code range.
module agc_gain_calc #(
    parameter int GW     = 7,
    parameter int DBW    = 8,
    parameter int TARGET = 9
) (
    input  logic [GW-1:0]  gain_prev,
    input  logic [DBW-1:0] db,
    output logic [GW-1:0]  gain_next
);
    localparam int SW = ((GW > DBW) ? GW : DBW) + 3;
    localparam logic signed [SW-1:0] GMAX = SW'((1 << GW) - 1);

    logic signed [SW-1:0] sum;

    assign sum = $signed(SW'(gain_prev)) + $signed(SW'(db)) - $signed(SW'(TARGET));

    always_comb begin
        if (sum < 0)
            gain_next = '0;
        else if (sum > GMAX)
            gain_next = '1;
        else
            gain_next = sum[GW-1:0];
    end
endmodule

// File: rtl/agc_settle_cnt.sv
// Counts settle cycles; done is high in the last one.
module agc_settle_cnt #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (en && !done)
            cnt <= cnt + 1'b1;
    end

    assign done = en && (cnt == CW'(N - 1));
endmodule

// File: rtl/preamble_agc.sv
module preamble_agc
    import preamble_agc_pkg::*;
#(
    parameter int PW         = 24,
    parameter int GW         = 7,
    parameter int GAIN_INIT  = 48,
    parameter int TARGET_DB  = 9,
    parameter int SETTLE_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pkt_end,
    input  logic          pwr_valid,
    input  logic [PW-1:0] pwr,
    output logic [GW-1:0] gain,
    output logic          gain_stb,
    output logic          busy,
    output logic          locked
);
    localparam int DBW = $clog2(PW * 3 + 4) + 1;

    agc_state_e     state, state_nx;
    logic [DBW-1:0] db_now, db_reg;
    logic [GW-1:0]  gain_nx;
    logic           settle_done;

    agc_db_lut #(.PW(PW), .DBW(DBW)) u_lut (
        .pwr (pwr),
        .db  (db_now)
    );

    agc_gain_calc #(.GW(GW), .DBW(DBW), .TARGET(TARGET_DB)) u_calc (
        .gain_prev (gain),
        .db        (db_reg),
        .gain_next (gain_nx)
    );

    agc_settle_cnt #(.N(SETTLE_CYC)) u_settle (
        .clk  (clk),
        .clr  (state != ST_SETTLE),
        .en   (state == ST_SETTLE),
        .done (settle_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)       state_nx = ST_MEAS1;
            ST_MEAS1:  if (pwr_valid)   state_nx = ST_UPD1;
            ST_UPD1:                    state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_nx = ST_MEAS2;
            ST_MEAS2:  if (pwr_valid)   state_nx = ST_UPD2;
            ST_UPD2:                    state_nx = ST_LOCKED;
            ST_LOCKED:                  state_nx = ST_LOCKED;
            default:                    state_nx = ST_IDLE;
        endcase
        if (pkt_end)
            state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain     <= GW'(GAIN_INIT);
            gain_stb <= 1'b0;
            db_reg   <= '0;
        end else begin
            gain_stb <= 1'b0;
            if ((state == ST_MEAS1 || state == ST_MEAS2) && pwr_valid)
                db_reg <= db_now;
            if ((state == ST_UPD1 || state == ST_UPD2) && !pkt_end) begin
                gain     <= gain_nx;
                gain_stb <= 1'b1;
            end
        end
    end

    always_comb begin
        busy   = 1'b0;
        locked = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_LOCKED: locked = 1'b1;
            default:   busy   = 1'b1;
        endcase
    end
endmodule

// File: rtl/preamble_agc_chk.sv
module preamble_agc_chk #(
    parameter int GW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          pkt_end,
    input logic [GW-1:0] gain,
    input logic          gain_stb,
    input logic          busy,
    input logic          locked
);
    logic seen;
    always_ff @(posedge clk) seen <= rst_n;

    // R5
    gain_change_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !$stable(gain) |-> gain_stb);

    // R5
    stb_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_stb |-> (busy || locked));

    // R2
    busy_lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && locked));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !pkt_end) |=> locked);

    // R8
    pkt_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> (!busy && !locked));

    // R8
    pkt_end_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> $stable(gain));
endmodule

bind preamble_agc preamble_agc_chk #(.GW(GW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pkt_end  (pkt_end),
    .gain     (gain),
    .gain_stb (gain_stb),
    .busy     (busy),
    .locked   (locked)
);

// File: tb/sim_preamble_agc.sv
module sim_preamble_agc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pkt_end = 1'b0;
    logic        pwr_valid = 1'b0;
    logic [23:0] pwr = '0;
    logic [6:0]  gain;
    logic        gain_stb;
    logic        busy;
    logic        locked;

    int checks = 0;
    int failures = 0;
    int model_gain = 48;
    int exp_q[$];
    int cyc = 0;
    int last_stb = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    preamble_agc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pkt_end(pkt_end),
        .pwr_valid(pwr_valid), .pwr(pwr), .gain(gain), .gain_stb(gain_stb),
        .busy(busy), .locked(locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R3 reference conversion
    function automatic int db_of(input logic [23:0] p);
        int k;
        int m;
        int t[4];
        logic [25:0] ext;
        t = '{0, 4, 7, 10};
        if (p == 0) return 0;
        k = 0;
        for (int i = 0; i < 24; i++) if (p[i]) k = i;
        ext = {p, 2'b00};
        m = int'(ext[k+1 -: 2]);
        return (12 * k + t[m] + 2) / 4;
    endfunction

    // R4 reference update
    function automatic int upd(input int g, input logic [23:0] p);
        int s;
        s = g + db_of(p) - 9;
        if (s < 0) s = 0;
        if (s > 127) s = 127;
        return s;
    endfunction

    // monitor: scoreboard pop and compare on each strobe
    always @(negedge clk) begin
        cyc++;
        if (rst_n && gain_stb) begin
            stb_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected strobe", int'(gain), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(gain) == e, "R4 gain", int'(gain), e);
            end
            if (stb_cnt % 2 == 0)
                check(cyc - last_stb == 18, "R6 settle spacing", cyc - last_stb, 18);
            last_stb = cyc;
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_stb();
        do @(negedge clk); while (!gain_stb);
    endtask

    // full packet: two measurements, settle junk held valid, optional start in settle
    task automatic run_pkt(input logic [23:0] p1, input logic [23:0] p2, input bit poke);
        model_gain = upd(model_gain, p1);
        exp_q.push_back(model_gain);
        model_gain = upd(model_gain, p2);
        exp_q.push_back(model_gain);
        pulse_start();
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        pwr_valid = 1'b1;
        pwr = p1;
        @(negedge clk);
        pwr_valid = 1'b0;
        wait_stb();
        pwr_valid = 1'b1;
        pwr = 24'hFFFFFF;
        for (int i = 0; i < 16; i++) begin
            start = poke && (i == 5);
            @(negedge clk);
        end
        start = 1'b0;
        pwr = p2;
        @(negedge clk);
        pwr_valid = 1'b0;
        wait_stb();
        check(locked == 1'b1, "R5 locked", locked, 1);
        check(busy == 1'b0, "R5 not busy", busy, 0);
        // R9: power words while locked
        pwr_valid = 1'b1;
        pwr = 24'h000001;
        repeat (3) @(negedge clk);
        pwr_valid = 1'b0;
        check(int'(gain) == model_gain, "R9 gain held", int'(gain), model_gain);
        pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
        check(locked == 1'b0 && busy == 1'b0, "R8 idle after end", {busy, locked}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(int'(gain) == 48, "R1 gain", int'(gain), 48);
        check(!busy && !locked && !gain_stb, "R1 flags", {busy, locked, gain_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: power in IDLE ignored
        pwr_valid = 1'b1;
        pwr = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        pwr_valid = 1'b0;
        check(int'(gain) == 48 && !busy, "R9 idle ignore", int'(gain), 48);
        // R3/R4 nominal
        run_pkt(24'h000400, 24'h000030, 1'b0);
        // R7 start inside settle
        run_pkt(24'h001000, 24'h000005, 1'b1);
        // R4 high clamp
        run_pkt(24'hFFFFFF, 24'hC00000, 1'b0);
        check(int'(gain) == 127, "R4 high clamp", int'(gain), 127);
        // R3 small words
        run_pkt(24'h000001, 24'h000003, 1'b0);
        // R4 low clamp
        for (int n = 0; n < 7; n++) run_pkt(24'h0, 24'h0, 1'b0);
        check(int'(gain) == 0, "R4 low clamp", int'(gain), 0);
        // R7 start while locked; R8 start with pkt_end
        run_pkt(24'h800000, 24'h000100, 1'b0);
        exp_q.push_back(upd(model_gain, 24'h002000));
        model_gain = exp_q[$];
        pulse_start();
        pwr_valid = 1'b1;
        pwr = 24'h002000;
        @(negedge clk);
        pwr_valid = 1'b0;
        wait_stb();
        // R8 abort during settle keeps first update
        pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
        check(!busy && !locked, "R8 abort", {busy, locked}, 0);
        repeat (20) @(negedge clk);
        check(int'(gain) == model_gain, "R8 gain kept", int'(gain), model_gain);
        stb_cnt = 0;
        // lock again, then start while locked
        run_pkt(24'h010000, 24'h000800, 1'b0);
        exp_q.push_back(upd(model_gain, 24'h000040));
        exp_q.push_back(upd(upd(model_gain, 24'h000040), 24'h000040));
        model_gain = exp_q[$];
        pulse_start();
        pwr_valid = 1'b1;
        pwr = 24'h000040;
        @(negedge clk);
        pwr_valid = 1'b0;
        wait_stb();
        pwr_valid = 1'b1;
        repeat (17) @(negedge clk);
        pwr_valid = 1'b0;
        wait_stb();
        pulse_start();
        repeat (3) @(negedge clk);
        check(locked && !busy, "R7 start in locked", {busy, locked}, 1);
        check(int'(gain) == model_gain, "R7 gain", int'(gain), model_gain);
        start = 1'b1;
        pkt_end = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pkt_end = 1'b0;
        check(!busy && !locked, "R8 end beats start", {busy, locked}, 0);
        repeat (3) @(negedge clk);
        check(!busy, "R8 stays idle", busy, 0);
        check(exp_q.size() == 0, "R5 all updates seen", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule